// File: doc/BRIEF.md
# Sample Queue with Watermark Interrupt

This block sits inside a sensor between the measurement path and the host register interface. Each time the internal sample strobe fires while the queue is switched on, one fixed-width record is stored. The host drains records in arrival order through a pop port. It can read how many records are waiting before it starts draining. A single control register selects the on/off state, the behaviour when the queue is full, the interrupt level, and the pin enable and polarity.

The interrupt pin is level-sensitive. It stays active for as long as the number of held records is at or above the programmed level. A write to the command address with the flush bit set empties the queue in one cycle. Switching the queue off only stops new records from entering; records already held stay in place.

Top module: `smpq_top`

## Requirements
- R1: After reset the held count is 0, the control register reads 0x0000, `popValid` is 0, and `wmPin` is 1 (the inactive level of the active-low default).
- R2: The control register at address 0 reads back as written. Bit 0 is enable, bit 1 is the full policy, bit 2 is pin enable, bit 3 is pin polarity, and bits 15:4 are the level field.
- R3: A record is stored only on a cycle where `smpValid` is 1 and the enable bit is 1. With enable at 0 the count does not grow.
- R4: `popData` shows the oldest held record while `popValid` is 1. A pop with `popReq` removes it, so records leave in arrival order.
- R5: With the policy bit at 0 and all 512 places used, a new sample with no pop in the same cycle is discarded. The count stays 512 and the oldest record is unchanged.
- R6: With the policy bit at 1 and the queue full, a new sample discards the oldest record and is stored. The count stays 512.
- R7: The count register at address 1 reports the number of held records, from 0 to 512. Writes to address 1 have no effect.
- R8: A write to address 2 with bit 5 set empties the queue by the next cycle, even when a sample or a pop arrives in the same cycle. A write to address 2 with bit 5 clear changes nothing.
- R9: The effective interrupt level is the level field plus one, limited to 511.
- R10: The pin is active when the pin enable is 1 and the count is at or above the effective level. Active means 1 when polarity is 1, and 0 when polarity is 0. Otherwise the pin drives the opposite value.
- R11: Clearing the enable bit keeps the held records and the count.
- R12: A pop request while the queue is empty is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| smpValid | input | 1 | Sample strobe from the measurement path |
| smpData | input | REC_W | Record presented with the strobe |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 control, 1 count, 2 command |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for `regAddr` (combinational) |
| popReq | input | 1 | Remove the oldest record |
| popData | output | REC_W | Oldest held record |
| popValid | output | 1 | At least one record is held |
| wmPin | output | 1 | Level-sensitive watermark interrupt |

## Verification
The bench fills the queue to exactly 512 records. It then tests both full policies: under the stop policy the head must stay put, and under the overwrite policy the head must move up by one while the count stays at 512. It flushes in the same cycle as a sample arrives; a design that let the sample win would report a count of 1. It also programs the largest level field to expose a missing 511 limit, which would leave the pin silent at 511 records. A long random run with small levels and both polarities catches pins that are off by one at the threshold or inverted.

// File: rtl/smpq_pkg.sv
package smpq_pkg;
  localparam int CTRL_W    = 16;
  localparam int LVL_W     = 12;
  localparam int FLUSH_BIT = 5;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_COUNT = 2'd1;
  localparam logic [1:0] ADDR_CMD   = 2'd2;

  // Field order fixes the bit positions seen by the host.
  typedef struct packed {
    logic [LVL_W-1:0] wmLevel;  // 15:4
    logic             wmPol;    // 3
    logic             wmEn;     // 2
    logic             ovwOld;   // 1
    logic             enable;   // 0
  } ctrlReg_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic dropOld;
    logic flush;
  } qStrobe_t;
endpackage

// File: rtl/smpq_ctrl.sv
module smpq_ctrl
  import smpq_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  smpValid,
  input  logic                  popReq,
  input  logic                  regWe,
  input  logic [1:0]            regAddr,
  input  logic [CTRL_W-1:0]     regWdata,
  output logic [CTRL_W-1:0]     regRdata,
  output qStrobe_t              strobe,
  output logic                  popValid,
  output logic                  wmPin
);
  localparam int WM_W   = LVL_W + 1;
  localparam int MAX_WM = DEPTH - 1;

  ctrlReg_t          ctrlQ;
  logic [CNT_W-1:0]  count;
  logic              flushNow, isFull, isEmpty, popDo, wantPush;
  logic [WM_W-1:0]   lvlPlus, effWm;
  logic              wmActive;

  always_ff @(posedge clk) begin
    if (!rstN)                                 ctrlQ <= '0;
    else if (regWe && regAddr == ADDR_CTRL)    ctrlQ <= ctrlReg_t'(regWdata);
  end

  always_comb begin
    flushNow = regWe && (regAddr == ADDR_CMD) && regWdata[FLUSH_BIT];
    isFull   = (count == CNT_W'(DEPTH));
    isEmpty  = (count == '0);
    popDo    = popReq && !isEmpty && !flushNow;
    wantPush = smpValid && ctrlQ.enable && !flushNow;
    strobe.flush   = flushNow;
    strobe.pop     = popDo;
    strobe.push    = wantPush && (!isFull || popDo || ctrlQ.ovwOld);
    strobe.dropOld = wantPush && isFull && !popDo && ctrlQ.ovwOld;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flushNow) count <= '0;
    else begin
      case ({strobe.push, strobe.pop || strobe.dropOld})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    lvlPlus  = WM_W'(ctrlQ.wmLevel) + 1'b1;
    effWm    = (lvlPlus > WM_W'(MAX_WM)) ? WM_W'(MAX_WM) : lvlPlus;
    wmActive = ctrlQ.wmEn && (WM_W'(count) >= effWm);
    wmPin    = ctrlQ.wmPol ? wmActive : !wmActive;
    popValid = !isEmpty;
    case (regAddr)
      ADDR_CTRL:  regRdata = CTRL_W'(ctrlQ);
      ADDR_COUNT: regRdata = CTRL_W'(count);
      default:    regRdata = '0;
    endcase
  end

  p_count_cap_r7: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  p_off_no_grow_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.enable |=> count <= $past(count));
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_CMD && regWdata[FLUSH_BIT]) |=> count == '0);
  p_stop_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && !ctrlQ.ovwOld && !popReq && !flushNow) |=> isFull);
  p_ovw_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && ctrlQ.ovwOld && smpValid && ctrlQ.enable && !flushNow) |=> isFull);
  p_idle_pin_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.wmEn |-> wmPin == !ctrlQ.wmPol);
endmodule

// File: rtl/smpq_store.sv
module smpq_store
  import smpq_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int REC_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  qStrobe_t         strobe,
  input  logic [REC_W-1:0] smpData,
  output logic [REC_W-1:0] popData
);
  logic [REC_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= smpData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push)                  wrPtr <= nextPtr(wrPtr);
      if (strobe.pop || strobe.dropOld) rdPtr <= nextPtr(rdPtr);
    end
  end

  assign popData = mem[rdPtr];

  p_drop_with_push_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dropOld |-> strobe.push && !strobe.pop);
  p_flush_ptrs_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> wrPtr == rdPtr);
endmodule

// File: rtl/smpq_top.sv
module smpq_top
  import smpq_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int REC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             smpValid,
  input  logic [REC_W-1:0] smpData,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [15:0]      regWdata,
  output logic [15:0]      regRdata,
  input  logic             popReq,
  output logic [REC_W-1:0] popData,
  output logic             popValid,
  output logic             wmPin
);
  qStrobe_t strobe;

  smpq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .smpValid(smpValid), .popReq(popReq),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .strobe(strobe), .popValid(popValid), .wmPin(wmPin)
  );

  smpq_store #(.DEPTH(DEPTH), .REC_W(REC_W)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .smpData(smpData), .popData(popData)
  );
endmodule

// File: tb/sim_smpq_top.sv
`timescale 1ns/1ps
module sim_smpq_top;
  localparam int DEPTH = 512;

  logic        clk = 0, rstN = 0;
  logic        smpValid = 0, regWe = 0, popReq = 0;
  logic [15:0] smpData = 0, regWdata = 0;
  logic [1:0]  regAddr = 0;
  logic [15:0] regRdata, popData;
  logic        popValid, wmPin;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [15:0] mq[$];
  logic [15:0] mCtrl = 0;

  always #2 clk = ~clk;

  smpq_top u0 (.clk(clk), .rstN(rstN), .smpValid(smpValid), .smpData(smpData),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .popReq(popReq), .popData(popData), .popValid(popValid), .wmPin(wmPin));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit expPin();
    int eff = int'(mCtrl[15:4]) + 1;
    bit act;
    if (eff > DEPTH - 1) eff = DEPTH - 1;
    act = mCtrl[2] && (mq.size() >= eff);
    return mCtrl[3] ? act : !act;
  endfunction

  // Model one clock edge from the inputs now driven, then advance.
  task automatic tick();
    bit flushNow = regWe && regAddr == 2'd2 && regWdata[5];
    bit popDo    = popReq && mq.size() > 0;
    bit full     = mq.size() == DEPTH;
    if (flushNow) mq.delete();
    else begin
      if (popDo) void'(mq.pop_front());
      if (smpValid && mCtrl[0]) begin
        if (!full || popDo) mq.push_back(smpData);
        else if (mCtrl[1]) begin void'(mq.pop_front()); mq.push_back(smpData); end
      end
    end
    if (regWe && regAddr == 2'd0) mCtrl = regWdata;
    @(posedge clk); #1;
    smpValid = 0; regWe = 0; popReq = 0;
  endtask

  task automatic checkAll(string tag);
    regWe = 0; regAddr = 2'd1; #1;
    chk({tag, " R4/R12 popValid"}, popValid, mq.size() > 0);
    if (mq.size() > 0) chk({tag, " R4 head"}, popData, mq[0]);
    chk({tag, " R7 count"}, regRdata, mq.size());
    chk({tag, " R10 pin"}, wmPin, expPin());
  endtask

  task automatic wrReg(logic [1:0] a, logic [15:0] d);
    regWe = 1; regAddr = a; regWdata = d; tick();
  endtask

  task automatic pushS(logic [15:0] d);
    smpValid = 1; smpData = d; tick();
  endtask

  task automatic popOne();
    popReq = 1; tick();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    finish();
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    checkAll("R1 reset");
    chk("R1 pin inactive high", wmPin, 1);
    regAddr = 2'd0; #1;
    chk("R1 ctrl zero", regRdata, 0);

    // R3 disabled: sample ignored
    pushS(16'h1111);
    checkAll("R3 disabled");
    chk("R3 count stays 0", regRdata, 0);

    // R2 readback and field layout; level field 2 -> watermark 3, active-high (R9 R10)
    wrReg(2'd0, 16'h002D);
    regAddr = 2'd0; #1;
    chk("R2 ctrl readback", regRdata, 16'h002D);
    pushS(16'hA001); pushS(16'hA002);
    checkAll("R10 below level");
    chk("R9 pin low at 2", wmPin, 0);
    pushS(16'hA003);
    chk("R9 pin high at 3", wmPin, 1);
    checkAll("R10 at level");
    wrReg(2'd0, 16'h0025);  // polarity 0: active-low
    chk("R10 active low", wmPin, 0);

    // R7 write to count ignored; R8 command without flush bit ignored
    wrReg(2'd1, 16'h0000);
    wrReg(2'd2, 16'hFFDF);
    checkAll("R7/R8 no effect");
    chk("R8 count kept", regRdata, 3);

    // R4 order
    popOne();
    chk("R4 second head", popData, 16'hA002);
    checkAll("R4 pop");

    // R11 clearing enable keeps contents
    wrReg(2'd0, 16'h0000);
    checkAll("R11 disable");
    chk("R11 count kept", regRdata, 2);

    // R12 pop on empty
    popOne(); popOne(); popOne();
    checkAll("R12 empty pop");
    wrReg(2'd0, 16'h0001);
    pushS(16'h0BAD);
    chk("R12 head after empty pop", popData, 16'h0BAD);
    checkAll("R12 refill");
    wrReg(2'd2, 16'h0020);

    // R5 fill to full, stop policy
    for (int i = 0; i < DEPTH; i++) pushS(16'(i));
    pushS(16'hBEEF);
    checkAll("R5 full stop");
    chk("R5 count 512", regRdata, DEPTH);
    chk("R5 head kept", popData, 0);

    // R6 overwrite oldest
    wrReg(2'd0, 16'h0003);
    pushS(16'hCAFE);
    checkAll("R6 overwrite");
    chk("R6 count 512", regRdata, DEPTH);
    chk("R6 head advanced", popData, 1);

    // R8 flush together with sample
    regWe = 1; regAddr = 2'd2; regWdata = 16'h0020; smpValid = 1; smpData = 16'h7777;
    tick();
    checkAll("R8 flush");
    chk("R8 empty", regRdata, 0);

    // R9 clamp: level field max -> 511
    wrReg(2'd0, 16'hFFFD);
    for (int i = 0; i < DEPTH - 2; i++) pushS(16'(i + 100));
    chk("R9 clamp below", wmPin, 0);
    pushS(16'h0511);
    chk("R9 clamp at 511", wmPin, 1);
    checkAll("R9 clamp");
    wrReg(2'd2, 16'h0020);

    // Random mix against the bench model
    for (int c = 0; c < 4000; c++) begin
      int r = $urandom % 1000;
      bool_drive: begin
        smpValid = ($urandom % 3) != 0;
        smpData  = 16'($urandom);
        popReq   = ((c / 700) % 2 == 0) ? (($urandom % 8) == 0) : (($urandom % 2) == 0);
        if (r < 20) begin
          regWe = 1; regAddr = 2'd0;
          regWdata = {12'($urandom % 40), 4'($urandom)} | 16'h0001;
        end else if (r < 24) begin
          regWe = 1; regAddr = 2'd2; regWdata = 16'($urandom);
        end else if (r < 28) begin
          regWe = 1; regAddr = 2'd1; regWdata = 16'($urandom);
        end
      end
      tick();
      checkAll("rand");
    end
    finish();
  end
endmodule